// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave-side protocol engine of a small serial memory that sits on a two-wire bus. It samples the clock and data lines with a much faster system clock and finds the start and stop conditions. It shifts in the device-address, word-address and data bytes and acknowledges each byte it accepts. During reads it returns stored bytes through an open-drain pull-down enable. A small internal byte array holds the contents.

A write commits one byte on the stop condition that ends the write command. The block then enters a self-timed busy phase of `WR_CYCLES` system clocks. While busy it ignores the bus completely, including start conditions. When the busy phase ends it returns to standby. A read returns the byte at the current address pointer and then advances the pointer. A dummy write followed by a repeated start gives a random read.

Top module: `eeprom_2w_slave`

## Requirements
- R1: With SCL high, an SDA fall is a start and an SDA rise is a stop. SDA changes while SCL is low are data bits. A stop that arrives before the data byte of a write stores nothing and starts no busy phase.
- R2: Bytes are sampled most significant bit first on the SCL rising edge. The first byte after a start is a 7-bit device address (`DEV_ADDR`, default 0x50) followed by a direction bit, where 1 means read. On a match the slave pulls SDA low through the ninth clock. On a mismatch it never pulls SDA and ignores the bus until the next start.
- R3: In a write command the slave acknowledges the word-address byte and one data byte.
- R4: A start received outside the busy phase aborts the command in progress, even in the middle of a byte, and decoding restarts at the device-address byte.
- R5: The stop that ends a write stores the data byte at the word address and sets the pointer to that address plus one. It then starts a busy phase of `WR_CYCLES` clocks. During the busy phase starts are ignored and the slave never pulls SDA.
- R6: When the busy phase is over the slave is in standby. It acknowledges new commands, and reads return the byte that was written.
- R7: A read drives the byte at the pointer MSB first and advances the pointer. When the master acknowledges, the next byte follows. When the master does not acknowledge, the slave releases SDA and goes to standby.
- R8: `sda_pull` rises only in the cycle after an SCL falling edge is detected, so it never starts pulling while SCL is high.
- R9: After reset the slave is in standby, `sda_pull` is 0, every byte of the array is 0x00 and the pointer is 0.
- R10: Word addresses and the pointer are taken modulo `DEPTH`, so address 0x13 selects location 3 and the pointer wraps from the last location to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Each SCL edge reaches the control logic three system clocks after it happens: two synchroniser stages and one edge register. Any change of `sda_pull` appears one clock after that. The bench therefore holds every SCL phase for ten system clocks and reads the acknowledge and the data bits in the middle of the high phase. A committed write keeps the slave busy for `WR_CYCLES` clocks counted from the detected stop. The bench probes the busy phase right after the stop and then waits `WR_CYCLES` plus a margin before it expects the slave to answer again.

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         DEPTH     = 16,
  parameter int         WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WADR, ST_WDAT, ST_RD, ST_BUSY} st_t;

  st_t           st;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    bitcnt;
  logic [7:0]    sr, tx, wbuf;
  logic [AW-1:0] ptr;
  logic [TW-1:0] tmr;
  logic          in_ack, rw, mack, pend;
  logic [7:0]    mem [DEPTH];

  logic scl_rise, scl_fall, scl_hi, start_c, stop_c;
  assign scl_rise = scl_q[1] & ~scl_q[2];
  assign scl_fall = ~scl_q[1] & scl_q[2];
  assign scl_hi   = scl_q[1] & scl_q[2];
  assign start_c  = scl_hi & sda_q[2] & ~sda_q[1];
  assign stop_c   = scl_hi & ~sda_q[2] & sda_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; sr <= '0; tx <= '0; wbuf <= '0; ptr <= '0;
      tmr <= '0; in_ack <= 1'b0; rw <= 1'b0; mack <= 1'b0; pend <= 1'b0; sda_pull <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (start_c) begin
      if (st != ST_BUSY) begin
        st <= ST_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_pull <= 1'b0; pend <= 1'b0;
      end
    end else if (stop_c) begin
      if (st != ST_BUSY) begin
        sda_pull <= 1'b0; in_ack <= 1'b0; bitcnt <= '0;
        if (pend) begin
          mem[ptr] <= wbuf; ptr <= ptr + 1'b1; pend <= 1'b0; st <= ST_BUSY; tmr <= '0;
        end else st <= ST_IDLE;
      end
    end else if (st == ST_BUSY) begin
      if (tmr == TW'(WR_CYCLES - 1)) st <= ST_IDLE;
      else tmr <= tmr + 1'b1;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          mack <= ~sda_q[1];
        end else begin
          sr <= {sr[6:0], sda_q[1]};
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8 && !in_ack) begin
          in_ack <= 1'b1;
          case (st)
            ST_DEV:  if (sr[7:1] == DEV_ADDR) begin sda_pull <= 1'b1; rw <= sr[0]; end
                     else st <= ST_IDLE;
            ST_WADR: begin sda_pull <= 1'b1; ptr <= sr[AW-1:0]; end
            ST_WDAT: begin sda_pull <= 1'b1; wbuf <= sr; pend <= 1'b1; end
            default: sda_pull <= 1'b0;
          endcase
        end else if (bitcnt == 4'd0 && in_ack) begin
          in_ack <= 1'b0;
          sda_pull <= 1'b0;
          case (st)
            ST_DEV:  if (rw) begin
                       st <= ST_RD; tx <= mem[ptr]; sda_pull <= ~mem[ptr][7]; ptr <= ptr + 1'b1;
                     end else st <= ST_WADR;
            ST_WADR: st <= ST_WDAT;
            ST_WDAT: st <= ST_IDLE;
            ST_RD:   if (mack) begin
                       tx <= mem[ptr]; sda_pull <= ~mem[ptr][7]; ptr <= ptr + 1'b1;
                     end else st <= ST_IDLE;
            default: st <= ST_IDLE;
          endcase
        end else if (st == ST_RD && !in_ack && bitcnt != 4'd0) begin
          sda_pull <= ~tx[3'd7 - bitcnt[2:0]];
        end
      end
    end

  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall)); // R8
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY) |-> !sda_pull); // R5
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && start_c && tmr != TW'(WR_CYCLES - 1)) |=> (st == ST_BUSY)); // R5
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && st != ST_BUSY) |=> (st == ST_DEV && bitcnt == 4'd0 && !sda_pull)); // R4
  AST_STOP_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !pend && st != ST_BUSY) |=> (st == ST_IDLE && !sda_pull)); // R1
endmodule

// File: tb/test_eeprom_2w_slave.sv
module test_eeprom_2w_slave;
  localparam int H   = 10;
  localparam int WRC = 300;
  localparam logic [15:0] VEC [4] = '{16'h00A5, 16'h073C, 16'h0F81, 16'h135E};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_pull;

  eeprom_2w_slave #(.DEV_ADDR(7'h50), .DEPTH(16), .WR_CYCLES(WRC)) i_eeprom_2w_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull(sda_pull));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0, r8_bad = 0;
  logic pull_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_pull && !pull_prev && m_scl) r8_bad++;
    pull_prev = sda_pull;
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw(int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(H);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
  endtask

  task automatic m_bit(logic b);
    m_sda = b; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0;
  endtask

  task automatic m_send(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H/2); ack = ~sda_bus; hw(H/2); m_scl = 1'b0;
  endtask

  task automatic m_recv(logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); m_scl = 1'b1; hw(H/2); b[i] = sda_bus; hw(H/2); m_scl = 1'b0;
    end
    m_sda = ~give_ack; hw(H); m_scl = 1'b1; hw(H); m_scl = 1'b0; m_sda = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    hw(5); rst_n = 1'b1; hw(5);
    chk("R9 pull after reset", sda_pull, 0);

    // R9: read at pointer 0 right after reset
    m_start(); m_send(8'hA1, a); chk("R9 read ack", a, 1);
    m_recv(1'b0, d); m_stop(); chk("R9 mem zero", d, 8'h00);

    // R2 R3 R5 R6 R10: write then random read back, vector table
    for (int k = 0; k < 4; k++) begin
      m_start(); m_send(8'hA0, a); chk("R2 dev ack", a, 1);
      m_send(VEC[k][15:8], a); chk("R3 addr ack", a, 1);
      m_send(VEC[k][7:0], a); chk("R3 data ack", a, 1);
      m_stop(); hw(WRC + 50);
      m_start(); m_send(8'hA0, a); m_send(VEC[k][15:8], a);
      m_start(); m_send(8'hA1, a); chk("R6 read ack", a, 1);
      m_recv(1'b0, d); m_stop(); chk("R7 random read", d, VEC[k][7:0]);
    end
    m_start(); m_send(8'hA0, a); m_send(8'h03, a);
    m_start(); m_send(8'hA1, a); m_recv(1'b0, d); m_stop();
    chk("R10 addr 0x13 wrapped to 3", d, 8'h5E);

    // R7 R10: sequential read wrapping from 0x0F to 0x00
    m_start(); m_send(8'hA0, a); m_send(8'h0F, a);
    m_start(); m_send(8'hA1, a);
    m_recv(1'b1, d); chk("R7 seq byte 0", d, 8'h81);
    m_recv(1'b0, d); chk("R10 seq wrap byte", d, 8'hA5);
    m_stop();

    // R2: wrong device address is not acknowledged
    m_start(); m_send(8'hB0, a); chk("R2 mismatch nack", a, 0);
    m_send(8'h00, a); chk("R2 ignored after mismatch", a, 0);
    m_stop();

    // R4: start in the middle of a byte restarts decoding
    m_start(); m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b0);
    m_start(); m_send(8'hA0, a); chk("R4 restart ack", a, 1);
    m_send(8'h07, a);
    m_start(); m_send(8'hA1, a); m_recv(1'b0, d); m_stop();
    chk("R4 read after restart", d, 8'h3C);

    // R1: stop before data byte writes nothing and is not busy
    m_start(); m_send(8'hA0, a); m_send(8'h00, a); m_stop();
    m_start(); m_send(8'hA1, a); chk("R1 no busy after early stop", a, 1);
    m_recv(1'b0, d); m_stop(); chk("R1 no write after early stop", d, 8'hA5);

    // R5 R6: busy phase ignores a start, then standby
    m_start(); m_send(8'hA0, a); m_send(8'h05, a); m_send(8'h77, a); m_stop();
    m_start(); m_send(8'hA0, a); chk("R5 busy nack", a, 0);
    m_stop(); hw(WRC + 50);
    m_start(); m_send(8'hA0, a); chk("R6 ack after busy", a, 1);
    m_send(8'h05, a);
    m_start(); m_send(8'hA1, a); m_recv(1'b0, d); m_stop();
    chk("R6 written byte", d, 8'h77);

    chk("R8 pull rise with SCL high", r8_bad, 0);
    summary();
    $finish;
  end
endmodule